// File: doc/BRIEF.md
# Multiplexed Address/Data Expansion Bus Controller

This block turns single-beat requests from an 8-bit processor with a 16-bit address space into timing on an external expansion bus. It divides the oscillator clock by four into a bus clock E and runs one bus cycle per E period. In the E-low half the low address byte leaves on a shared 8-bit port; in the E-high half that port carries the data byte. The high address byte has a port of its own, and an active-high address strobe lets an external transparent latch catch the low address before the shared port turns over to data.

The bus cycles without a break. When no request is waiting, a cycle still runs as a read-direction idle cycle: the last address stays on the pins and the shared port floats while E is high. A request is taken at the final oscillator clock of a cycle and carried out in the cycle that follows, so two writes can run back to back with the direction line held low between them. Read data driven by an external device is sampled at the end of E high and returned to the processor side with a one-clock valid pulse. The block also drives the active-low write enable for external memory.

Top module: `muxbus_ctrl`

## Requirements
- R1: E repeats with a period of four clocks of `clk`: low for two clocks, high for two. After reset it is low for the two clocks that follow the first rising edge of `clk`.
- R2: `bus_as` is high only during the first clock of each bus cycle (the first of the two E-low clocks), and E is low whenever `bus_as` is high.
- R3: `addr_hi` carries bits 15..8 of the address of the cycle and holds that value for all four clocks of the cycle. An idle cycle keeps the address of the cycle before it.
- R4: While E is low, `ad_oe` is 1 and `ad_out` carries bits 7..0 of the address of the cycle.
- R5: In a write cycle, while E is high, `ad_oe` is 1 and `ad_out` carries the write data.
- R6: In a read cycle or an idle cycle, `ad_oe` is 0 while E is high.
- R7: `bus_rw` is 0 (write) for all four clocks of a write cycle and 1 (read) for read and idle cycles. It changes only at a cycle boundary, so it stays 0 without a gap across back-to-back writes.
- R8: `bus_we_n` is the NAND of E and the inverse of `bus_rw`: it is 0 exactly while E is high in a write cycle.
- R9: `req_ready` is 1 only during the last clock of each bus cycle. A request with `req_valid` = 1 on that clock is carried out in the next cycle (`req_write` = 1 selects a write); `req_valid` on any other clock is ignored and the next cycle is idle.
- R10: At the rising edge of `clk` that ends E high in a read cycle, `ad_in` is captured. During the next clock `rd_valid` is 1 and `rd_data` holds the captured byte. `rd_valid` stays 0 after write and idle cycles.
- R11: While `rst_n` is 0: E = 0, `bus_as` = 1, `bus_rw` = 1, `bus_we_n` = 1, `ad_oe` = 1, `addr_hi` = 0, `req_ready` = 0, `rd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, four times the E rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request is taken on this clock |
| rd_data | output | 8 | Byte read from the bus |
| rd_valid | output | 1 | One-clock pulse marking `rd_data` as new |
| bus_e | output | 1 | Bus clock E |
| bus_as | output | 1 | Address strobe, enable of an external transparent latch |
| bus_rw | output | 1 | Direction: 1 read, 0 write |
| bus_we_n | output | 1 | External memory write enable, active low |
| addr_hi | output | 8 | Address bits 15..8 |
| ad_out | output | 8 | Shared port, outgoing value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, incoming value |

## Verification
Two events meet on the last clock of a read cycle: the capture of the read byte from `ad_in` and the acceptance of the next request, which also reloads the address and direction. The bench provokes this by presenting each request exactly on that clock, so reads are followed at once by writes to other addresses and by further reads. It then judges at the first clock of the new cycle that `rd_data` holds the byte driven by the bench in the previous cycle, not anything tied to the new address, while `addr_hi`, `ad_out` and `bus_rw` already show the new request.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    // Quarter of a bus cycle; bit 1 is the level of E.
    typedef enum logic [1:0] {
        PH_ADR_LATCH = 2'd0,
        PH_ADR_HOLD  = 2'd1,
        PH_DAT_OPEN  = 2'd2,
        PH_DAT_CLOSE = 2'd3
    } bus_phase_e;

    typedef struct packed {
        bus_phase_e ph;
        logic       e;
        logic       as;
    } phase_state_t;

endpackage

// File: rtl/muxbus_phase.sv
module muxbus_phase
    import muxbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic bus_e,
    output logic bus_as,
    output logic cyc_last
);

    phase_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = bus_phase_e'(st_q.ph + 2'd1);
        st_d.e  = st_d.ph[1];
        st_d.as = (st_d.ph == PH_ADR_LATCH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph <= PH_ADR_LATCH;
            st_q.e  <= 1'b0;
            st_q.as <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_e    = st_q.e;
    assign bus_as   = st_q.as;
    assign cyc_last = rst_n && (st_q.ph == PH_DAT_CLOSE);

endmodule

// File: rtl/muxbus_xfer.sv
module muxbus_xfer #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_last,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] ad_in,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_wdata,
    output logic          cur_wr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          wr;
        logic          rd;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } xfer_state_t;

    xfer_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = cyc_last && s_q.rd;
        if (cyc_last && s_q.rd) begin
            s_d.rdata = ad_in;
        end
        if (cyc_last) begin
            if (req_valid) begin
                s_d.addr  = req_addr;
                s_d.wdata = req_wdata;
                s_d.wr    = req_write;
                s_d.rd    = !req_write;
            end else begin
                s_d.wr = 1'b0;
                s_d.rd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_addr  = s_q.addr;
    assign cur_wdata = s_q.wdata;
    assign cur_wr    = s_q.wr;
    assign rd_data   = s_q.rdata;
    assign rd_valid  = s_q.rvalid;

endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             bus_e,
    input  logic [AW-1:0]    cur_addr,
    input  logic [DW-1:0]    cur_wdata,
    input  logic             cur_wr,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             bus_rw,
    output logic             bus_we_n
);

    always_comb begin
        addr_hi  = cur_addr[AW-1:DW];
        ad_out   = bus_e ? cur_wdata : cur_addr[DW-1:0];
        ad_oe    = !bus_e || cur_wr;
        bus_rw   = !cur_wr;
        bus_we_n = !(bus_e && !bus_rw);
    end

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             bus_e,
    output logic             bus_as,
    output logic             bus_rw,
    output logic             bus_we_n,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in
);

    logic          cyc_last;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    logic          cur_wr;

    muxbus_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_e    (bus_e),
        .bus_as   (bus_as),
        .cyc_last (cyc_last)
    );

    muxbus_xfer #(.AW(AW), .DW(DW)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_last  (cyc_last),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_wr    (cur_wr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    muxbus_pins #(.AW(AW), .DW(DW)) u_pins (
        .bus_e     (bus_e),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_wr    (cur_wr),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .bus_rw    (bus_rw),
        .bus_we_n  (bus_we_n)
    );

    assign req_ready = cyc_last;

endmodule

// File: rtl/muxbus_ctrl_chk.sv
module muxbus_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             bus_e,
    input logic             bus_as,
    input logic             bus_rw,
    input logic             bus_we_n,
    input logic [AW-DW-1:0] addr_hi,
    input logic             ad_oe
);

    assert_e_high_two_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_e) |=> bus_e);

    assert_as_then_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> (!bus_as && !bus_e));

    assert_as_at_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_e) |-> bus_as);

    assert_as_e_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> !bus_e);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as |-> $stable(addr_hi));

    assert_drive_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_e |-> ad_oe);

    assert_read_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_e && bus_rw) |-> !ad_oe);

    assert_rw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as |-> $stable(bus_rw));

    assert_we_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> (bus_e && !bus_rw));

    assert_ready_e_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_e && !bus_as));

    assert_rdvalid_pos_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> bus_as);

endmodule

bind muxbus_ctrl muxbus_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .bus_e     (bus_e),
    .bus_as    (bus_as),
    .bus_rw    (bus_rw),
    .bus_we_n  (bus_we_n),
    .addr_hi   (addr_hi),
    .ad_oe     (ad_oe)
);

// File: tb/sim_muxbus_ctrl.sv
module sim_muxbus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        bus_e, bus_as, bus_rw, bus_we_n, ad_oe;
    logic [7:0]  addr_hi, ad_out;
    logic [7:0]  ad_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic        pend_rd = 1'b0;
    logic [7:0]  pend_val = '0;
    logic [15:0] last_addr = '0;

    always #10 clk = !clk;

    muxbus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .bus_e(bus_e), .bus_as(bus_as),
        .bus_rw(bus_rw), .bus_we_n(bus_we_n), .addr_hi(addr_hi), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in)
    );

    // {gap, write, addr, wdata, read byte}
    localparam logic [33:0] VECS [0:7] = '{
        {1'b0, 1'b1, 16'h1234, 8'hA5, 8'h00},
        {1'b0, 1'b1, 16'h1235, 8'h5A, 8'h00},
        {1'b0, 1'b0, 16'h8000, 8'h00, 8'h3C},
        {1'b0, 1'b0, 16'hFFFF, 8'h00, 8'hC3},
        {1'b1, 1'b1, 16'h00FF, 8'h00, 8'h00},
        {1'b0, 1'b0, 16'h7F01, 8'h00, 8'h81},
        {1'b0, 1'b1, 16'hAA55, 8'hFF, 8'h00},
        {1'b1, 1'b0, 16'h0100, 8'h00, 8'h7E}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Entered at a falling edge inside the last clock of a cycle; any
    // request is already on the inputs. Checks the four clocks of the cycle.
    task automatic run_cycle(input logic txn, input logic wr, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rb, input logic poke);
        logic rw_exp;
        logic [15:0] ea;
        rw_exp = !(txn && wr);
        ea = txn ? a : last_addr;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 as first clock", bus_as, 1);
        chk("R1 e low clk0", bus_e, 0);
        chk("R3 addr_hi clk0", addr_hi, ea[15:8]);
        chk("R4 oe clk0", ad_oe, 1);
        chk("R4 ad_out clk0", ad_out, ea[7:0]);
        chk("R7 rw clk0", bus_rw, rw_exp);
        chk("R10 rd_valid pulse", rd_valid, pend_rd);
        if (pend_rd) chk("R10 rd_data", rd_data, pend_val);
        chk("R9 ready clk0", req_ready, 0);
        pend_rd = 1'b0;
        if (poke) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hDEAD; req_wdata = 8'h11;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 e low clk1", bus_e, 0);
        chk("R2 as low clk1", bus_as, 0);
        chk("R3 addr_hi clk1", addr_hi, ea[15:8]);
        chk("R4 ad_out clk1", ad_out, ea[7:0]);
        chk("R7 rw clk1", bus_rw, rw_exp);
        chk("R8 we_n clk1", bus_we_n, 1);
        chk("R10 rd_valid clear", rd_valid, 0);
        @(negedge clk);
        chk("R1 e high clk2", bus_e, 1);
        chk("R3 addr_hi clk2", addr_hi, ea[15:8]);
        chk(wr && txn ? "R5 oe write" : "R6 float", ad_oe, txn && wr);
        if (txn && wr) chk("R5 write data", ad_out, wd);
        chk("R8 we_n clk2", bus_we_n, !(txn && wr));
        chk("R7 rw clk2", bus_rw, rw_exp);
        ad_in = txn ? rb : 8'hEE;
        @(negedge clk);
        chk("R1 e high clk3", bus_e, 1);
        chk("R9 ready last", req_ready, 1);
        chk("R8 we_n clk3", bus_we_n, !(txn && wr));
        chk("R7 rw clk3", bus_rw, rw_exp);
        chk("R3 addr_hi clk3", addr_hi, ea[15:8]);
        pend_rd = txn && !wr;
        pend_val = rb;
        last_addr = ea;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 e", bus_e, 0);
        chk("R11 as", bus_as, 1);
        chk("R11 rw", bus_rw, 1);
        chk("R11 we_n", bus_we_n, 1);
        chk("R11 oe", ad_oe, 1);
        chk("R11 addr_hi", addr_hi, 0);
        chk("R11 ready", req_ready, 0);
        chk("R11 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        // R1: low for two clocks after release, then high
        @(negedge clk); chk("R1 e after reset 1", bus_e, 0);
        @(negedge clk); chk("R1 e after reset 2", bus_e, 1);
        @(negedge clk); chk("R9 first ready", req_ready, 1);
        for (int i = 0; i < 8; i++) begin
            if (VECS[i][33]) begin
                run_cycle(1'b0, 1'b0, 16'h0, 8'h0, 8'h0, 1'b1); // R9 poke ignored
                run_cycle(1'b0, 1'b0, 16'h0, 8'h0, 8'h0, 1'b0);
            end
            req_valid = 1'b1;
            req_write = VECS[i][32];
            req_addr  = VECS[i][31:16];
            req_wdata = VECS[i][15:8];
            run_cycle(1'b1, VECS[i][32], VECS[i][31:16], VECS[i][15:8], VECS[i][7:0], 1'b0);
        end
        run_cycle(1'b0, 1'b0, 16'h0, 8'h0, 8'h0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule